// File: doc/BRIEF.md
# Boundary-scan built-in self-test engine

This block carries out the self-test operations of the boundary register on an octal registered buffer. The register has eight input cells, eight output cells and two control cells. Each cell has a shift stage and a shadow latch. A 2-bit opcode picks one of four operations:

- sampling the input pins while the output cells are inverted;
- a 16-bit pseudo-random pattern generator;
- a 16-bit parallel signature compressor;
- a split mode, in which an 8-bit signature register on the input cells runs beside an 8-bit pattern generator on the output cells.

The operation advances by one step on each rising TCK edge, but only while the run-test instruction is loaded and the TAP controller sits in Run-Test/Idle. The shadow latches take the new stage contents on the following falling edge. The output shadows drive the output pins and the input shadows feed the core logic. One control shadow bit gates the pin drivers.

A seed or a complete register image is placed into the shift stages through a parallel load port, which stands in for the scan path. An update strobe copies the stages to the shadows. Outside the run condition all state holds, so that a result can be read back from `shift_q`.

Top module: `bist_scan_engine`

## Requirements
- R1: An active-low asynchronous reset clears all 18 shift stages and all 18 shadows. After reset, `core_in`, `pin_out` and `pin_oe` are 0.
- R2: A step happens on a rising TCK edge only when both `runtest_en` and `tap_idle` are 1. If either one is 0 and `load_en` is 0, all shift stages keep their values.
- R3: With opcode 00, a step loads the input stages (bits 7:0) with `pin_in` and inverts the output stages (bits 15:8).
- R4: With opcode 01, a step shifts the 16 data stages s[15:0] as {s0^s2^s3^s5, s[15:1]}.
- R5: With opcode 01 and all 16 data stages at zero, a step leaves them at zero.
- R6: With opcode 10, a step computes the R4 result and then XORs `pin_in` into bits 7:0.
- R7: With opcode 11, a step sets the input stages i[7:0] to {i0^i2^i3^i4, i[7:1]} ^ `pin_in`. In the same step the output stages o[7:0] become {o0^o2^o3^o4, o[7:1]}.
- R8: The two control stages (bits 17:16) never change during a step.
- R9: The shadows copy all stages on the falling TCK edge that follows a rising edge with a step or with `update_en` high. Otherwise the shadows hold. `pin_out` is shadow bits 15:8 and `core_in` is shadow bits 7:0.
- R10: `pin_oe` is shadow bit 16. A value of 1 means the output pins are actively driven and 0 means high impedance.
- R11: With no step, a rising edge with `load_en` high writes `load_data` into all 18 stages. A step takes priority over a load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock; the stages use its rising edge and the shadows its falling edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| runtest_en | input | 1 | The run-test instruction is loaded |
| tap_idle | input | 1 | The TAP controller is in Run-Test/Idle |
| opcode | input | 2 | Self-test operation select |
| pin_in | input | 8 | Input pin data |
| load_en | input | 1 | Parallel load of the stages |
| load_data | input | 18 | Image for the parallel load |
| update_en | input | 1 | Copy the stages to the shadows on the next falling edge |
| shift_q | output | 18 | Shift stage contents |
| core_in | output | 8 | Input shadows, fed to the core logic |
| pin_out | output | 8 | Output shadows, driven to the pins |
| pin_oe | output | 1 | Output pin drive enable |

## Verification
The hardest case to reach is the lock-up state of the pattern generator. The engine starts only from whatever the stages hold, so the bench uses the load port to plant an all-zero data image while the control bits are nonzero, and then runs the generator for several steps. It also drives each half of the run condition on its own, so that hold is separated from step. For the signature modes, a long run with pin values that change every cycle makes any wrong tap or wrong XOR position spread into every later cycle of the comparison.

// File: rtl/bist_scan_engine.sv
module bist_scan_engine #(
  parameter int CELLS = 8,
  parameter logic [2*CELLS-1:0] TAPS_FULL = 16'h002D,
  parameter logic [CELLS-1:0]   TAPS_HALF = 8'h1D
) (
  input  logic                 tck,
  input  logic                 rst_n,
  input  logic                 runtest_en,
  input  logic                 tap_idle,
  input  logic [1:0]           opcode,
  input  logic [CELLS-1:0]     pin_in,
  input  logic                 load_en,
  input  logic [2*CELLS+1:0]   load_data,
  input  logic                 update_en,
  output logic [2*CELLS+1:0]   shift_q,
  output logic [CELLS-1:0]     core_in,
  output logic [CELLS-1:0]     pin_out,
  output logic                 pin_oe
);
  localparam int DW = 2 * CELLS;
  localparam int TW = DW + 2;

  logic            step, upd_q;
  logic [TW-1:0]   shadow_q;
  logic [CELLS-1:0] in_s, out_s, in_nx, out_nx;
  logic [DW-1:0]   full, full_step;

  assign step      = runtest_en & tap_idle;
  assign in_s      = shift_q[CELLS-1:0];
  assign out_s     = shift_q[DW-1:CELLS];
  assign full      = shift_q[DW-1:0];
  assign full_step = {^(full & TAPS_FULL), full[DW-1:1]};

  always_comb begin
    case (opcode)
      2'b00:   {out_nx, in_nx} = {~out_s, pin_in};
      2'b01:   {out_nx, in_nx} = full_step;
      2'b10:   {out_nx, in_nx} = full_step ^ {{CELLS{1'b0}}, pin_in};
      default: begin
        in_nx  = {^(in_s & TAPS_HALF), in_s[CELLS-1:1]} ^ pin_in;
        out_nx = {^(out_s & TAPS_HALF), out_s[CELLS-1:1]};
      end
    endcase
  end

  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n) begin
      shift_q <= '0;
      upd_q   <= 1'b0;
    end else begin
      upd_q <= step | update_en;
      if (step)
        shift_q[DW-1:0] <= {out_nx, in_nx};
      else if (load_en)
        shift_q <= load_data;
    end
  end

  always_ff @(negedge tck or negedge rst_n) begin
    if (!rst_n)
      shadow_q <= '0;
    else if (upd_q)
      shadow_q <= shift_q;
  end

  assign core_in = shadow_q[CELLS-1:0];
  assign pin_out = shadow_q[DW-1:CELLS];
  assign pin_oe  = shadow_q[DW];
endmodule

module bist_scan_engine_chk #(
  parameter int CELLS = 8
) (
  input logic                 tck,
  input logic                 rst_n,
  input logic                 runtest_en,
  input logic                 tap_idle,
  input logic [1:0]           opcode,
  input logic [CELLS-1:0]     pin_in,
  input logic                 load_en,
  input logic [2*CELLS+1:0]   shift_q
);
  localparam int DW = 2 * CELLS;

  p_hold_r2: assert property (@(posedge tck) disable iff (!rst_n)
    (!(runtest_en && tap_idle) && !load_en) |=> $stable(shift_q));

  p_toggle_r3: assert property (@(posedge tck) disable iff (!rst_n)
    (runtest_en && tap_idle && opcode == 2'b00) |=>
      (shift_q[DW-1:CELLS] == ~$past(shift_q[DW-1:CELLS]) &&
       shift_q[CELLS-1:0] == $past(pin_in)));

  p_lock_r5: assert property (@(posedge tck) disable iff (!rst_n)
    (runtest_en && tap_idle && opcode == 2'b01 && shift_q[DW-1:0] == '0) |=>
      (shift_q[DW-1:0] == '0));

  p_ctrl_r8: assert property (@(posedge tck) disable iff (!rst_n)
    (runtest_en && tap_idle) |=> $stable(shift_q[DW+1:DW]));
endmodule

bind bist_scan_engine bist_scan_engine_chk #(.CELLS(CELLS)) u_chk (
  .tck(tck), .rst_n(rst_n), .runtest_en(runtest_en), .tap_idle(tap_idle),
  .opcode(opcode), .pin_in(pin_in), .load_en(load_en), .shift_q(shift_q)
);

// File: tb/bist_scan_engine_tb.sv
module bist_scan_engine_tb;
  logic        tck = 1'b0;
  logic        rst_n = 1'b0;
  logic        runtest_en = 1'b0, tap_idle = 1'b0, load_en = 1'b0, update_en = 1'b0;
  logic [1:0]  opcode = 2'b00;
  logic [7:0]  pin_in = 8'h00;
  logic [17:0] load_data = '0;
  logic [17:0] shift_q;
  logic [7:0]  core_in, pin_out;
  logic        pin_oe;

  int total = 0, bad = 0;
  logic [17:0] m_shift = '0, m_shadow = '0;
  logic        m_upd = 1'b0;

  always #10 tck = ~tck;

  bist_scan_engine u_dut (
    .tck(tck), .rst_n(rst_n), .runtest_en(runtest_en), .tap_idle(tap_idle),
    .opcode(opcode), .pin_in(pin_in), .load_en(load_en), .load_data(load_data),
    .update_en(update_en), .shift_q(shift_q), .core_in(core_in),
    .pin_out(pin_out), .pin_oe(pin_oe)
  );

  function automatic logic [15:0] gen16(input logic [15:0] s);
    return {s[0] ^ s[2] ^ s[3] ^ s[5], s[15:1]};
  endfunction

  function automatic logic [7:0] gen8(input logic [7:0] s);
    return {s[0] ^ s[2] ^ s[3] ^ s[4], s[7:1]};
  endfunction

  task automatic compare(input string tag);
    logic [35:0] got, exp;
    got = {shift_q, core_in, pin_out, pin_oe, 1'b0};
    exp = {m_shift, m_shadow[7:0], m_shadow[15:8], m_shadow[16], 1'b0};
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s shift=%h core=%h pins=%h oe=%b expected shift=%h core=%h pins=%h oe=%b",
               tag, shift_q, core_in, pin_out, pin_oe,
               m_shift, m_shadow[7:0], m_shadow[15:8], m_shadow[16]);
    end
  endtask

  task automatic cyc(input logic run, input logic idle, input logic [1:0] op,
                     input logic [7:0] pins, input logic ld, input logic [17:0] ldd,
                     input logic upd, input string tag);
    runtest_en = run; tap_idle = idle; opcode = op; pin_in = pins;
    load_en = ld; load_data = ldd; update_en = upd;
    @(posedge tck);
    if (run && idle) begin
      case (op)
        2'b00: m_shift[15:0] = {~m_shift[15:8], pins};
        2'b01: m_shift[15:0] = gen16(m_shift[15:0]);
        2'b10: m_shift[15:0] = gen16(m_shift[15:0]) ^ {8'h00, pins};
        default: m_shift[15:0] = {gen8(m_shift[15:8]), gen8(m_shift[7:0]) ^ pins};
      endcase
    end else if (ld) begin
      m_shift = ldd;
    end
    m_upd = (run && idle) || upd;
    @(negedge tck);
    if (m_upd) m_shadow = m_shift;
    #2;
    compare(tag);
  endtask

  initial begin
    #4_000_000;
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (2) @(negedge tck);
    #2;
    compare("R1");
    rst_n = 1'b1;

    cyc(0, 0, 2'b00, 8'h00, 1, 18'h312C5, 1, "R11 R10");
    for (int i = 0; i < 5; i++) cyc(1, 1, 2'b00, 8'(i * 37 + 5), 0, '0, 0, "R3 R9");
    for (int i = 0; i < 3; i++) cyc(1, 0, 2'b00, 8'(i * 91 + 7), 0, '0, 0, "R2 run only");
    for (int i = 0; i < 3; i++) cyc(0, 1, 2'b01, 8'(i * 13 + 1), 0, '0, 0, "R2 idle only");
    cyc(1, 1, 2'b01, 8'hFF, 1, 18'h00000, 0, "R11 step over load");
    for (int i = 0; i < 20; i++) cyc(1, 1, 2'b01, 8'(i * 29), 0, '0, 0, "R4");
    cyc(0, 0, 2'b00, 8'h00, 1, 18'h10000, 0, "R5 zero seed");
    for (int i = 0; i < 4; i++) cyc(1, 1, 2'b01, 8'hA5, 0, '0, 0, "R5");
    cyc(0, 0, 2'b00, 8'h00, 1, 18'h0ACE1, 0, "R11 seed");
    for (int i = 0; i < 20; i++) cyc(1, 1, 2'b10, 8'(i * 53 + 3), 0, '0, 0, "R6");
    for (int i = 0; i < 20; i++) cyc(1, 1, 2'b11, 8'(i * 71 + 9), 0, '0, 0, "R7");
    cyc(0, 0, 2'b00, 8'h00, 1, 18'h2BEEF, 0, "R9 load without update");
    cyc(0, 0, 2'b00, 8'h00, 0, '0, 1, "R10 update oe low");
    for (int i = 0; i < 3; i++) cyc(1, 1, 2'(i + 1), 8'(i * 17), 0, '0, 0, "R8");
    cyc(0, 1, 2'b00, 8'h3C, 0, '0, 0, "R9 shadows hold");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule